// File: doc/BRIEF.md
# Subtract and Logic Flag ALU

This combinational slice evaluates one of four operations on two operands at an 8, 16 or 32-bit width: plain subtraction, subtraction with an incoming borrow, a bitwise AND whose result is not written back (a test), and bitwise XOR. Along with the result it produces a write-enable for that result and six condition flags: carry, overflow, auxiliary carry, zero, sign and parity.

The arithmetic flags do not come from separate comparators. The slice forms one per-bit borrow-chain vector from the minuend, the subtrahend and the raw difference. Carry, overflow and auxiliary carry are then single bits, or the XOR of two bits, taken from that vector. The position of each bit depends on the selected width. Zero and sign only look at the bits of the selected width, and the result bits above that width are driven to zero. The surrounding datapath owns the flag register. It updates the auxiliary-carry flag only while the auxiliary write-enable is high.

Top module: `sl_flag_alu`

## Requirements
- R1: With op_sel_i = 0 (subtract), result_o equals (opa_i − opb_i) modulo 2^n, where n is the selected width. carry_in_i has no effect on any output.
- R2: With op_sel_i = 1 (subtract with borrow), result_o equals (opa_i − opb_i − carry_in_i) modulo 2^n.
- R3: For both subtract operations, flag_c_o is 1 exactly when the unsigned n-bit minuend is smaller than the n-bit subtrahend plus the borrow actually applied (a borrow out of bit n−1).
- R4: For both subtract operations, flag_o_o is 1 exactly when the signed difference of the n-bit operands, minus the applied borrow, falls outside the range −2^(n−1) to 2^(n−1)−1.
- R5: For both subtract operations, flag_a_o is 1 exactly when the low nibble of the minuend is smaller than the low nibble of the subtrahend plus the applied borrow, at every width, and flag_a_we_o is 1.
- R6: flag_z_o is 1 exactly when the n-bit result is zero. flag_s_o equals bit n−1 of the result. Bits of result_o at positions n and above are 0.
- R7: flag_p_o is 1 exactly when bits 7:0 of the result hold an even number of ones.
- R8: With op_sel_i = 2 (test), result_o shows the n-bit AND of the operands, result_we_o is 0, and flag_c_o and flag_o_o are 0. Zero, sign and parity follow R6 and R7 on the AND value.
- R9: With op_sel_i = 3 (XOR), result_o is the n-bit XOR of the operands, result_we_o is 1, and flag_c_o and flag_o_o are 0. For both arithmetic operations result_we_o is 1.
- R10: For the test and XOR operations, flag_a_o and flag_a_we_o are both 0.
- R11: width_sel_i selects n: 0 gives 8 bits, 1 gives 16 bits, and 2 and 3 both give 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Minuend, or first logic operand |
| opb_i | input | 32 | Subtrahend, or second logic operand |
| carry_in_i | input | 1 | Incoming carry flag, used only as a borrow by subtract with borrow |
| op_sel_i | input | 2 | Operation: 0 subtract, 1 subtract with borrow, 2 test, 3 XOR |
| width_sel_i | input | 2 | Width: 0 is 8-bit, 1 is 16-bit, 2 and 3 are 32-bit |
| result_o | output | 32 | Result, zero above the selected width |
| result_we_o | output | 1 | Result write enable, low for test |
| flag_c_o | output | 1 | Carry (borrow) flag |
| flag_o_o | output | 1 | Signed overflow flag |
| flag_a_o | output | 1 | Auxiliary carry (borrow out of bit 3) |
| flag_a_we_o | output | 1 | Write enable for the auxiliary flag |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |
| flag_p_o | output | 1 | Even parity of result bits 7:0 |

## Verification
The slice holds no state, so any fault appears at the ports in the same evaluation as the inputs that expose it. A wrong borrow-chain term, or a wrong bit position taken from it, shows as a carry, overflow or auxiliary flag that disagrees with an unsigned or signed comparison. For the 8-bit width this is caught on every operand pair, because those are swept exhaustively. A bad width decode shows as nonzero upper result bits, or as a zero or sign flag taken from the wrong bit. Wrong handling of the incoming borrow shows as a subtract result that changes with carry_in_i.

// File: rtl/sl_alu_pkg.sv
// Package: shared operation and width codes for the subtract/logic flag ALU.
// Assumes the op and width encodings in the brief are fixed by the decoder.
package sl_alu_pkg;
    typedef enum logic [1:0] {
        OP_SUB  = 2'd0,
        OP_SBB  = 2'd1,
        OP_TEST = 2'd2,
        OP_XOR  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32B = 2'd3
    } wid_e;

    localparam int NARROW_MSB = 7;
    localparam int MID_MSB    = 15;
endpackage

// File: rtl/sl_diff_chain.sv
// Module: raw difference and per-bit borrow-chain vector.
// Each chain bit is the borrow leaving that bit position.
// Assumes that the borrow input is already qualified by the operation.
module sl_diff_chain #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] min_i,
    input  logic [DATA_W-1:0] sub_i,
    input  logic              bin_i,
    output logic [DATA_W-1:0] diff_o,
    output logic [DATA_W-1:0] chain_o
);
    logic [DATA_W-1:0] bin_ext;

    // Widen the single borrow bit to the operand width.
    always_comb begin
        bin_ext = {{(DATA_W-1){1'b0}}, bin_i};
    end

    // Raw wrap-around difference over the full datapath.
    always_comb begin
        diff_o = min_i - sub_i - bin_ext;
    end

    // One borrow-chain cell per bit position.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_cell
            assign chain_o[gi] = (diff_o[gi] & (~min_i[gi] | sub_i[gi]))
                               | (~min_i[gi] & sub_i[gi]);
        end
    endgenerate
endmodule

// File: rtl/sl_width_view.sv
// Module: width-dependent view of the result and of the borrow chain.
// Masks the result to the selected width, and picks the top two chain bits and
// the sign bit. It also derives zero (selected width) and parity (low byte).
// Assumes DATA_W is 32, because codes 2 and 3 both select the full width.
module sl_width_view #(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] chain_i,
    input  logic [1:0]        wid_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sign_o,
    output logic              zero_o,
    output logic              par_o,
    output logic              chain_top_o,
    output logic              chain_next_o
);
    import sl_alu_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  msb_idx;
    logic [IDX_W-1:0]  nxt_idx;
    logic [DATA_W-1:0] keep;

    // Decode the width code into the index of the top result bit.
    always_comb begin
        case (wid_e'(wid_i))
            WID_8:   msb_idx = IDX_W'(NARROW_MSB);
            WID_16:  msb_idx = IDX_W'(MID_MSB);
            default: msb_idx = IDX_W'(DATA_W-1);
        endcase
        nxt_idx = msb_idx - 1'b1;
    end

    // Keep mask: one comparator per bit against the top index.
    genvar gk;
    generate
        for (gk = 0; gk < DATA_W; gk++) begin : g_keep
            assign keep[gk] = (IDX_W'(gk) <= msb_idx);
        end
    endgenerate

    // Masked result and the flags that depend only on it.
    always_comb begin
        res_o        = raw_i & keep;
        sign_o       = res_o[msb_idx];
        zero_o       = ~|res_o;
        par_o        = ~^res_o[PAR_W-1:0];
        chain_top_o  = chain_i[msb_idx];
        chain_next_o = chain_i[nxt_idx];
    end
endmodule

// File: rtl/sl_flag_pack.sv
// Module: final flag and write-enable selection per operation class.
// Arithmetic operations take carry, overflow and auxiliary carry from the
// chain. Logic operations clear them and do not write the auxiliary flag.
// Assumes that zero, sign and parity are already computed on the masked result.
module sl_flag_pack (
    input  logic is_arith_i,
    input  logic is_test_i,
    input  logic chain_top_i,
    input  logic chain_next_i,
    input  logic chain_aux_i,
    input  logic zero_i,
    input  logic sign_i,
    input  logic par_i,
    output logic res_we_o,
    output logic c_o,
    output logic o_o,
    output logic a_o,
    output logic a_we_o,
    output logic z_o,
    output logic s_o,
    output logic p_o
);
    // Gate the chain-derived flags by operation class.
    always_comb begin
        c_o    = is_arith_i & chain_top_i;
        o_o    = is_arith_i & (chain_top_i ^ chain_next_i);
        a_o    = is_arith_i & chain_aux_i;
        a_we_o = is_arith_i;
    end

    // Result-based flags pass straight through. Test suppresses the write.
    always_comb begin
        z_o      = zero_i;
        s_o      = sign_i;
        p_o      = par_i;
        res_we_o = ~is_test_i;
    end

    // Logic operations must never report a carry or an overflow.
    always_comb begin
        if (!is_arith_i) begin
            AST_LOGIC_NO_CARRY: assert (!c_o && !o_o); // R9
        end
    end
endmodule

// File: rtl/sl_flag_alu.sv
// Module: top of the subtract/logic flag ALU (combinational).
// It selects the arithmetic or logic result and views it at the chosen width.
// The flags it reports come from one borrow-chain vector.
// Assumes: the caller holds the flag register and uses the write enables.
module sl_flag_alu #(
    parameter int DATA_W  = 32,
    parameter int AUX_BIT = 3,
    parameter int PAR_W   = 8
) (
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic        carry_in_i,
    input  logic [1:0]  op_sel_i,
    input  logic [1:0]  width_sel_i,
    output logic [31:0] result_o,
    output logic        result_we_o,
    output logic        flag_c_o,
    output logic        flag_o_o,
    output logic        flag_a_o,
    output logic        flag_a_we_o,
    output logic        flag_z_o,
    output logic        flag_s_o,
    output logic        flag_p_o
);
    import sl_alu_pkg::*;

    op_e               op;
    logic              is_arith;
    logic              is_test;
    logic              bin;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] chain;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] res_view;
    logic              v_sign, v_zero, v_par, v_top, v_next;

    // Operation decode. Only subtract-with-borrow lets the carry in.
    always_comb begin
        op       = op_e'(op_sel_i);
        is_arith = (op == OP_SUB) || (op == OP_SBB);
        is_test  = (op == OP_TEST);
        bin      = (op == OP_SBB) & carry_in_i;
    end

    sl_diff_chain #(.DATA_W(DATA_W)) u_chain (
        .min_i   (opa_i),
        .sub_i   (opb_i),
        .bin_i   (bin),
        .diff_o  (diff),
        .chain_o (chain)
    );

    // Logic result and the choice between the arithmetic and logic paths.
    always_comb begin
        logic_res = is_test ? (opa_i & opb_i) : (opa_i ^ opb_i);
        raw       = is_arith ? diff : logic_res;
    end

    sl_width_view #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_view (
        .raw_i        (raw),
        .chain_i      (chain),
        .wid_i        (width_sel_i),
        .res_o        (res_view),
        .sign_o       (v_sign),
        .zero_o       (v_zero),
        .par_o        (v_par),
        .chain_top_o  (v_top),
        .chain_next_o (v_next)
    );

    sl_flag_pack u_pack (
        .is_arith_i   (is_arith),
        .is_test_i    (is_test),
        .chain_top_i  (v_top),
        .chain_next_i (v_next),
        .chain_aux_i  (chain[AUX_BIT]),
        .zero_i       (v_zero),
        .sign_i       (v_sign),
        .par_i        (v_par),
        .res_we_o     (result_we_o),
        .c_o          (flag_c_o),
        .o_o          (flag_o_o),
        .a_o          (flag_a_o),
        .a_we_o       (flag_a_we_o),
        .z_o          (flag_z_o),
        .s_o          (flag_s_o),
        .p_o          (flag_p_o)
    );

    // Drive the visible result from the width view.
    always_comb begin
        result_o = res_view;
    end

    // Cross-checks between the decode, the chain and the width view.
    always_comb begin
        if (op_sel_i == 2'd2) begin
            AST_TEST_NO_WRITE: assert (!result_we_o); // R8
        end
        if (op_sel_i[1]) begin
            AST_LOGIC_AUX_CLEAR: assert (!flag_a_o && !flag_a_we_o); // R10
        end
        if (width_sel_i == 2'd0) begin
            AST_NARROW_UPPER_ZERO: assert (result_o[31:8] == 24'd0); // R6
        end
        if (width_sel_i == 2'd1) begin
            AST_MID_UPPER_ZERO: assert (result_o[31:16] == 16'd0); // R11
        end
        AST_ZERO_FLAG: assert (flag_z_o == (result_o == 32'd0)); // R6
        if (op_sel_i == 2'd0 && width_sel_i[1]) begin
            AST_SUB_BORROW_CMP: assert (flag_c_o == (opa_i < opb_i)); // R3
        end
    end
endmodule

// File: tb/sl_flag_alu_test.sv
// Bench: an exhaustive 8-bit sweep, then corner and random vectors at 16 and 32
// bits. Expected values come from integer arithmetic in the bench.
module sl_flag_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa, opb;
    logic        cin;
    logic [1:0]  op, wid;
    logic [31:0] res;
    logic        we, fc, fo, fa, fawe, fz, fs, fp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sl_flag_alu uut (
        .opa_i       (opa),
        .opb_i       (opb),
        .carry_in_i  (cin),
        .op_sel_i    (op),
        .width_sel_i (wid),
        .result_o    (res),
        .result_we_o (we),
        .flag_c_o    (fc),
        .flag_o_o    (fo),
        .flag_a_o    (fa),
        .flag_a_we_o (fawe),
        .flag_z_o    (fz),
        .flag_s_o    (fs),
        .flag_p_o    (fp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: op=%0d wid=%0d a=%h b=%h cin=%0b act=%h exp=%h",
                     tag, op, wid, opa, opb, cin, act, exp);
        end
    endtask

    // Drive one vector, let it settle, and compare every output against the model.
    task automatic run(input logic [1:0] o, input logic [1:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic ci);
        longint n, mask, half, da, db, bb, full, sa, sb, sfull, r;
        logic ec, eo, ea, eawe, ewe;
        opa = a; opb = b; cin = ci; op = o; wid = w;
        #1;
        n    = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        mask = (64'sd1 <<< n) - 1;
        half = 64'sd1 <<< (n - 1);
        da   = longint'(a) & mask;
        db   = longint'(b) & mask;
        if (o[1] == 1'b0) begin
            bb    = (o == 2'd1) ? longint'(ci) : 0;
            full  = da - db - bb;
            r     = full & mask;
            sa    = (da >= half) ? da - 2*half : da;
            sb    = (db >= half) ? db - 2*half : db;
            sfull = sa - sb - bb;
            ec    = (full < 0);
            eo    = (sfull < -half) || (sfull > half - 1);
            ea    = ((da & 15) < (db & 15) + bb);
            eawe  = 1'b1;
            ewe   = 1'b1;
            chk(o == 2'd0 ? "R1 sub result" : "R2 sbb result", res, 32'(r));
            chk("R3 carry", 32'(fc), 32'(ec));
            chk("R4 overflow", 32'(fo), 32'(eo));
            chk("R5 aux", 32'(fa), 32'(ea));
            chk("R5 aux we", 32'(fawe), 32'(eawe));
            chk("R9 arith we", 32'(we), 32'(ewe));
        end else begin
            r = (o == 2'd2) ? (da & db) : (da ^ db);
            chk(o == 2'd2 ? "R8 test value" : "R9 xor result", res, 32'(r));
            chk(o == 2'd2 ? "R8 test we" : "R9 xor we", 32'(we), 32'(o == 2'd3));
            chk(o == 2'd2 ? "R8 carry clear" : "R9 carry clear", 32'(fc), 32'd0);
            chk(o == 2'd2 ? "R8 ovf clear" : "R9 ovf clear", 32'(fo), 32'd0);
            chk("R10 aux clear", 32'(fa), 32'd0);
            chk("R10 aux we clear", 32'(fawe), 32'd0);
        end
        chk("R6 zero", 32'(fz), 32'(r == 0));
        chk("R6 sign", 32'(fs), 32'((r >> (n - 1)) & 1));
        chk("R7 parity", 32'(fp), 32'(~^r[7:0]));
    endtask

    initial begin
        opa = '0; opb = '0; cin = 1'b0; op = 2'd0; wid = 2'd0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Quiet state: all-zero inputs give a zero result with zero and parity set (R6, R7).
        chk("R6 idle result", res, 32'd0);
        chk("R6 idle zero", 32'(fz), 32'd1);
        chk("R7 idle parity", 32'(fp), 32'd1);

        // Exhaustive 8-bit sweep with random upper bits (R1 to R10).
        for (int o = 0; o < 4; o++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        run(2'(o), 2'd0, {$urandom() & 32'hFFFFFF00} | 32'(a),
                            {$urandom() & 32'hFFFFFF00} | 32'(b), 1'(ci));
                    end
                end
            end
        end

        // R1: carry_in has no effect on plain subtract (same vector, both carries).
        run(2'd0, 2'd2, 32'h0000_0005, 32'h0000_0005, 1'b1);
        chk("R1 cin ignored zero", 32'(fz), 32'd1);

        // Corner operands at 16 and 32 bits, including width code 3 (R11).
        for (int w = 1; w < 4; w++) begin
            for (int o = 0; o < 4; o++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    run(2'(o), 2'(w), 32'h8000_8000, 32'h0000_0001, 1'(ci));
                    run(2'(o), 2'(w), 32'h7FFF_7FFF, 32'hFFFF_FFFF, 1'(ci));
                    run(2'(o), 2'(w), 32'h0000_0000, 32'h0000_0000, 1'(ci));
                    run(2'(o), 2'(w), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'(ci));
                    run(2'(o), 2'(w), 32'h0001_0000, 32'h0000_0001, 1'(ci));
                    for (int k = 0; k < 1500; k++) begin
                        run(2'(o), 2'(w), $urandom(), $urandom(), 1'(ci));
                    end
                end
            end
        end

        // R11: code 3 behaves as 32-bit on a borrow that crosses bit 16.
        run(2'd0, 2'd3, 32'h0001_0000, 32'h0000_0001, 1'b0);
        chk("R11 code3 full width", res, 32'h0000_FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule